// File: doc/BRIEF.md
# Command Slot Fetch Engine

This block accepts commands from a host and places them in a queue of 31 numbered command slots. The queue feeds a command executor that runs downstream. A host can issue a command in two ways. On the direct path it names a slot whose request block already sits in local memory, and the slot number goes straight into the execution queue. On the indirect path it writes a 64-bit request-block address, as two 32-bit halves, into that slot's activation register. Writing the upper half places the slot number in a fetch queue.

A fetch state machine takes one slot at a time from the fetch queue. It captures the slot's activation address and marks the slot active. It then asks a bus-master engine for a 64-byte read from host memory into local slot memory, at a local base of slot × 128. When the engine returns a one-cycle done pulse, the machine passes the slot number to the execution queue. The block also keeps a vector of Active bits, one per slot. Completion logic clears these bits through a per-slot clear input.

The execution queue output and the master-read request are valid/ready streams. An item is transferred on a clock edge where valid and ready are both high. While ready is low, the producer keeps valid and the payload unchanged. Host writes, the clear vector and the done pulse are plain single-cycle strobes with no back-pressure. A push into a full queue is dropped and recorded in a sticky flag.

Top module: `cmd_slot_fetch`

## Requirements
- R1: After reset, exec_valid, mrd_valid, fetch_ovf and exec_ovf are 0 and all bits of active are 0.
- R2: A direct write (dir_wr high, dir_slot 0..30) appends dir_slot to the execution queue and sets active[dir_slot] in the next cycle. No master read is requested for it.
- R3: An activation write with act_hi = 0 stores act_data as bits 31:0 of the slot's address and queues nothing. A write with act_hi = 1 stores bits 63:32 and appends the slot to the fetch queue.
- R4: When the fetch machine is idle and the fetch queue is non-empty, it removes the head slot and sets its Active bit. From the next cycle it raises mrd_valid, with mrd_addr set to the slot's 64-bit activation address, mrd_lbase = slot × 128 and mrd_len = 64. All of these stay stable until mrd_ready is seen high.
- R5: After the request is accepted, the machine waits for an mrd_done pulse, then appends the slot to the execution queue and returns to idle. Only one fetch is in progress at a time, and mrd_done outside the wait is ignored.
- R6: exec_valid/exec_slot present the oldest queued slot. The entry is removed on an edge where exec_ready is high, and it is held unchanged while exec_ready is low.
- R7: If a direct write and the fetch machine's enqueue fall in the same cycle, the direct slot is enqueued first. The fetched slot is enqueued in the first later cycle that has no direct write.
- R8: Writes that name slot 31, on either path, have no effect on the queues or on active.
- R9: A high bit of slot_clr clears that Active bit. A set of the same bit in the same cycle wins.
- R10: A push into a full queue is dropped and sets that queue's sticky flag (fetch_ovf or exec_ovf), which only reset clears.
- R11: Each queue holds FIFO_DEPTH (default 32) entries; an entry removed in the same cycle makes room for the push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_wr | input | 1 | Direct-issue write strobe |
| dir_slot | input | 5 | Slot number for direct issue |
| act_wr | input | 1 | Activation register write strobe |
| act_hi | input | 1 | 1 selects the upper address half (and queues a fetch), 0 the lower half |
| act_slot | input | 5 | Slot whose activation register is written |
| act_data | input | 32 | Address half being written |
| slot_clr | input | 31 | Per-slot Active clear |
| exec_valid | output | 1 | Execution queue has an entry |
| exec_ready | input | 1 | Executor takes the head entry |
| exec_slot | output | 5 | Head slot of the execution queue |
| mrd_valid | output | 1 | Master read request valid |
| mrd_ready | input | 1 | Master engine accepts the request |
| mrd_addr | output | 64 | Host address of the request block |
| mrd_lbase | output | 12 | Local memory byte base (slot × 128) |
| mrd_len | output | 7 | Transfer length in bytes (64) |
| mrd_done | input | 1 | One-cycle completion pulse for the accepted read |
| active | output | 31 | Per-slot Active bits |
| fetch_ovf | output | 1 | Sticky fetch-queue overflow |
| exec_ovf | output | 1 | Sticky execution-queue overflow |

## Verification
The assertions check, on every cycle, the handshake properties: request and queue-head payloads hold while back-pressured, the overflow flags never drop, slot 31 never reaches the execution queue, and a direct issue always sets its Active bit. What only the bench can show is ordering and content. This covers the 64-bit address assembled from two halves, the slot order when direct and fetched pushes collide, the exact capacity at which a push is dropped, and the set-over-clear rule. A cycle-accurate queue model in the bench compares these against the ports.

// File: rtl/cmd_slot_pkg.sv
package cmd_slot_pkg;
  localparam int NSLOT      = 31;
  localparam int SLOT_W     = 5;
  localparam int ADDR_W     = 64;
  localparam int HALF_W     = ADDR_W / 2;
  localparam int PRB_BYTES  = 64;
  localparam int SLOT_BYTES = 128;
  localparam int SLOT_SH    = $clog2(SLOT_BYTES);
  localparam int LBASE_W    = SLOT_W + SLOT_SH;
  localparam int LEN_W      = $clog2(PRB_BYTES) + 1;

  typedef enum logic [1:0] {
    FS_IDLE = 2'd0,
    FS_REQ  = 2'd1,
    FS_WAIT = 2'd2,
    FS_PUSH = 2'd3
  } fetch_state_e;
endpackage

// File: rtl/slot_fifo.sv
module slot_fifo #(
  parameter int W     = 5,
  parameter int DEPTH = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         nonempty,
  output logic         ovf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          full, do_pop, do_push;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full     = (cnt == CW'(DEPTH));
  assign nonempty = (cnt != '0);
  assign do_pop   = pop && nonempty;
  assign do_push  = push && (!full || do_pop);
  assign dout     = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      if (do_push && !do_pop)      cnt <= cnt + 1'b1;
      else if (do_pop && !do_push) cnt <= cnt - 1'b1;
      if (push && !do_push) ovf <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end
endmodule

// File: rtl/act_regfile.sv
module act_regfile import cmd_slot_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              hi,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [HALF_W-1:0] wr_data,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              hi_push
);
  localparam int NREG = 2 ** SLOT_W;

  logic [ADDR_W-1:0] regs [NREG];
  logic              wr_ok;

  assign wr_ok   = wr && (wr_slot < SLOT_W'(NSLOT));
  assign hi_push = wr_ok && hi;
  assign rd_addr = regs[rd_slot];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (wr_ok) begin
      if (hi) regs[wr_slot][ADDR_W-1:HALF_W] <= wr_data;
      else    regs[wr_slot][HALF_W-1:0]      <= wr_data;
    end
  end
endmodule

// File: rtl/fetch_fsm.sv
module fetch_fsm import cmd_slot_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fq_nonempty,
  input  logic [ADDR_W-1:0] head_addr,
  output logic              fq_pop,
  output logic              set_valid,
  output logic [SLOT_W-1:0] cur_slot,
  input  logic [SLOT_W-1:0] head_slot,
  output logic              req_valid,
  input  logic              req_ready,
  input  logic              req_done,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              exec_blocked,
  output logic              exec_push
);
  fetch_state_e      st_q;
  logic [SLOT_W-1:0] slot_q;
  logic [ADDR_W-1:0] addr_q;

  assign fq_pop    = (st_q == FS_IDLE) && fq_nonempty;
  assign set_valid = fq_pop;
  assign req_valid = (st_q == FS_REQ);
  assign req_addr  = addr_q;
  assign cur_slot  = slot_q;
  assign exec_push = (st_q == FS_PUSH) && !exec_blocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FS_IDLE;
      slot_q <= '0;
      addr_q <= '0;
    end else begin
      unique case (st_q)
        FS_IDLE: if (fq_nonempty) begin
          slot_q <= head_slot;
          addr_q <= head_addr;
          st_q   <= FS_REQ;
        end
        FS_REQ:  if (req_ready)    st_q <= FS_WAIT;
        FS_WAIT: if (req_done)     st_q <= FS_PUSH;
        FS_PUSH: if (!exec_blocked) st_q <= FS_IDLE;
        default: st_q <= FS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cmd_slot_fetch.sv
module cmd_slot_fetch import cmd_slot_pkg::*; #(
  parameter int FIFO_DEPTH = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dir_wr,
  input  logic [SLOT_W-1:0]  dir_slot,
  input  logic               act_wr,
  input  logic               act_hi,
  input  logic [SLOT_W-1:0]  act_slot,
  input  logic [HALF_W-1:0]  act_data,
  input  logic [NSLOT-1:0]   slot_clr,
  output logic               exec_valid,
  input  logic               exec_ready,
  output logic [SLOT_W-1:0]  exec_slot,
  output logic               mrd_valid,
  input  logic               mrd_ready,
  output logic [ADDR_W-1:0]  mrd_addr,
  output logic [LBASE_W-1:0] mrd_lbase,
  output logic [LEN_W-1:0]   mrd_len,
  input  logic               mrd_done,
  output logic [NSLOT-1:0]   active,
  output logic               fetch_ovf,
  output logic               exec_ovf
);
  logic              dir_ok, hi_push;
  logic              fq_nonempty, fq_pop;
  logic [SLOT_W-1:0] fq_head, cur_slot;
  logic [ADDR_W-1:0] head_addr;
  logic              fsm_set, fsm_push;
  logic              eq_push;
  logic [SLOT_W-1:0] eq_din;

  assign dir_ok = dir_wr && (dir_slot < SLOT_W'(NSLOT));

  act_regfile u_regs (
    .clk(clk), .rst_n(rst_n), .wr(act_wr), .hi(act_hi), .wr_slot(act_slot),
    .wr_data(act_data), .rd_slot(fq_head), .rd_addr(head_addr), .hi_push(hi_push)
  );

  slot_fifo #(.W(SLOT_W), .DEPTH(FIFO_DEPTH)) u_fetch_q (
    .clk(clk), .rst_n(rst_n), .push(hi_push), .din(act_slot), .pop(fq_pop),
    .dout(fq_head), .nonempty(fq_nonempty), .ovf(fetch_ovf)
  );

  fetch_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .fq_nonempty(fq_nonempty), .head_addr(head_addr),
    .fq_pop(fq_pop), .set_valid(fsm_set), .cur_slot(cur_slot), .head_slot(fq_head),
    .req_valid(mrd_valid), .req_ready(mrd_ready), .req_done(mrd_done),
    .req_addr(mrd_addr), .exec_blocked(dir_ok), .exec_push(fsm_push)
  );

  assign eq_push = dir_ok || fsm_push;
  assign eq_din  = dir_ok ? dir_slot : cur_slot;

  slot_fifo #(.W(SLOT_W), .DEPTH(FIFO_DEPTH)) u_exec_q (
    .clk(clk), .rst_n(rst_n), .push(eq_push), .din(eq_din),
    .pop(exec_ready), .dout(exec_slot), .nonempty(exec_valid), .ovf(exec_ovf)
  );

  assign mrd_lbase = LBASE_W'(cur_slot) << SLOT_SH;
  assign mrd_len   = LEN_W'(PRB_BYTES);

  for (genvar i = 0; i < NSLOT; i++) begin : g_active
    logic set_i;
    assign set_i = (dir_ok && dir_slot == SLOT_W'(i)) ||
                   (fsm_set && fq_head == SLOT_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           active[i] <= 1'b0;
      else if (set_i)       active[i] <= 1'b1;
      else if (slot_clr[i]) active[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/cmd_slot_fetch_chk.sv
module cmd_slot_fetch_chk import cmd_slot_pkg::*; (
  input logic               clk,
  input logic               rst_n,
  input logic               dir_wr,
  input logic [SLOT_W-1:0]  dir_slot,
  input logic               exec_valid,
  input logic               exec_ready,
  input logic [SLOT_W-1:0]  exec_slot,
  input logic               mrd_valid,
  input logic               mrd_ready,
  input logic [ADDR_W-1:0]  mrd_addr,
  input logic [LBASE_W-1:0] mrd_lbase,
  input logic [NSLOT-1:0]   active,
  input logic               fetch_ovf,
  input logic               exec_ovf
);
  // R4: request payload held while back-pressured
  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mrd_valid && !mrd_ready |=> mrd_valid && $stable(mrd_addr) && $stable(mrd_lbase));

  // R6: queue head held while the executor is not ready
  a_r6_exec_hold: assert property (@(posedge clk) disable iff (!rst_n)
    exec_valid && !exec_ready |=> exec_valid && $stable(exec_slot));

  // R10: overflow flags are sticky
  a_r10_fetch_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ovf |=> fetch_ovf);
  a_r10_exec_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    exec_ovf |=> exec_ovf);

  // R8: slot 31 never reaches the execution queue
  a_r8_no_slot31: assert property (@(posedge clk) disable iff (!rst_n)
    exec_valid |-> exec_slot != SLOT_W'(NSLOT));

  // R2: direct issue marks the slot active
  a_r2_direct_active: assert property (@(posedge clk) disable iff (!rst_n)
    dir_wr && dir_slot < SLOT_W'(NSLOT) |=> |(active & (NSLOT'(1) << $past(dir_slot))));
endmodule

bind cmd_slot_fetch cmd_slot_fetch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dir_wr(dir_wr), .dir_slot(dir_slot),
  .exec_valid(exec_valid), .exec_ready(exec_ready), .exec_slot(exec_slot),
  .mrd_valid(mrd_valid), .mrd_ready(mrd_ready), .mrd_addr(mrd_addr),
  .mrd_lbase(mrd_lbase), .active(active), .fetch_ovf(fetch_ovf), .exec_ovf(exec_ovf)
);

// File: tb/cmd_slot_fetch_test.sv
module cmd_slot_fetch_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dir_wr = 1'b0;
  logic [4:0]  dir_slot = '0;
  logic        act_wr = 1'b0, act_hi = 1'b0;
  logic [4:0]  act_slot = '0;
  logic [31:0] act_data = '0;
  logic [30:0] slot_clr = '0;
  logic        exec_valid, exec_ready = 1'b0;
  logic [4:0]  exec_slot;
  logic        mrd_valid, mrd_ready = 1'b0, mrd_done = 1'b0;
  logic [63:0] mrd_addr;
  logic [11:0] mrd_lbase;
  logic [6:0]  mrd_len;
  logic [30:0] active;
  logic        fetch_ovf, exec_ovf;

  cmd_slot_fetch uut (.*);

  always #5 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0;
  string tag = "R1";
  bit done_flag = 0;

  // behavioural reference model
  int          fq[$], eq[$];
  logic [63:0] mregs [32];
  bit   [30:0] mact;
  int          mst, mcur;
  logic [63:0] maddr;
  bit          mfo, meo;

  always @(posedge clk) begin
    if (!rst_n) begin
      fq.delete(); eq.delete();
      foreach (mregs[i]) mregs[i] = '0;
      mact = '0; mst = 0; mcur = 0; maddr = '0; mfo = 0; meo = 0;
    end else begin
      bit [30:0] setv;
      bit dir_ok, fpush, fsm_eq, epop;
      int fsm_slot;
      setv = '0;
      dir_ok = dir_wr && dir_slot < 31;
      fpush  = act_wr && act_hi && act_slot < 31;
      epop   = exec_ready && eq.size() > 0;
      fsm_eq = 0; fsm_slot = mcur;
      case (mst)
        0: if (fq.size() > 0) begin
             mcur = fq.pop_front(); maddr = mregs[mcur]; setv[mcur] = 1; mst = 1;
           end
        1: if (mrd_ready) mst = 2;
        2: if (mrd_done) mst = 3;
        default: if (!dir_ok) begin fsm_eq = 1; mst = 0; end
      endcase
      if (act_wr && act_slot < 31) begin
        if (act_hi) mregs[act_slot][63:32] = act_data;
        else        mregs[act_slot][31:0]  = act_data;
      end
      if (fpush) begin
        if (fq.size() < 32) fq.push_back(act_slot); else mfo = 1;
      end
      if (epop) void'(eq.pop_front());
      if (dir_ok || fsm_eq) begin
        if (eq.size() < 32) eq.push_back(dir_ok ? int'(dir_slot) : fsm_slot); else meo = 1;
      end
      if (dir_ok) setv[dir_slot] = 1;
      mact = (mact & ~slot_clr) | setv;
    end
  end

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic cmp_all();
    chk("exec_valid", exec_valid, eq.size() > 0);
    if (eq.size() > 0) chk("exec_slot", exec_slot, eq[0]);
    chk("mrd_valid", mrd_valid, mst == 1);
    if (mst == 1) begin
      chk("mrd_addr", mrd_addr, maddr);
      chk("mrd_lbase", mrd_lbase, mcur * 128);
      chk("mrd_len", mrd_len, 64);
    end
    chk("active", active, mact);
    chk("fetch_ovf", fetch_ovf, mfo);
    chk("exec_ovf", exec_ovf, meo);
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
    cmp_all();
  endtask

  task automatic host_dir(int s);
    dir_wr = 1; dir_slot = 5'(s); tick(); dir_wr = 0;
  endtask

  task automatic host_act(int s, bit hi, logic [31:0] d);
    act_wr = 1; act_hi = hi; act_slot = 5'(s); act_data = d; tick(); act_wr = 0;
  endtask

  task automatic accept_req();
    mrd_ready = 1;
    for (int k = 0; k < 50 && !mrd_valid; k++) tick();
    tick();
    mrd_ready = 0;
  endtask

  task automatic finish_up();
    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_up();
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    tag = "R1"; cmp_all();
    chk("reset active", active, 0);
    chk("reset exec_valid", exec_valid, 0);
    rst_n = 1; tick();

    tag = "R2"; host_dir(5); host_dir(30);
    chk("R2 active5", active[5], 1);
    chk("R2 no mrd", mrd_valid, 0);

    tag = "R3"; host_act(3, 0, 32'h89ABCDEF); tick(); tick();
    chk("R3 lo write no fetch", mrd_valid, 0);
    host_act(3, 1, 32'h01234567);
    tick();
    tag = "R4";
    chk("R4 mrd_valid", mrd_valid, 1);
    chk("R4 addr", mrd_addr, 64'h0123456789ABCDEF);
    chk("R4 lbase", mrd_lbase, 3 * 128);
    chk("R4 active3", active[3], 1);
    tick(); tick(); tick();
    accept_req();
    tag = "R5"; mrd_done = 1; tick(); mrd_done = 0; tick(); tick();
    chk("R5 exec order", exec_slot, 5);

    tag = "R6"; exec_ready = 1; tick(); tick(); tick(); tick(); exec_ready = 0;
    chk("R6 drained", exec_valid, 0);

    tag = "R7"; host_act(7, 0, 32'h00000100); host_act(7, 1, 32'h00000002);
    accept_req(); tick();
    mrd_done = 1; tick(); mrd_done = 0;
    host_dir(9); tick();
    chk("R7 first direct", exec_slot, 9);
    exec_ready = 1; tick(); exec_ready = 0;
    chk("R7 then fetched", exec_slot, 7);
    exec_ready = 1; tick(); exec_ready = 0;

    tag = "R5"; mrd_done = 1; tick(); mrd_done = 0;
    chk("R5 stray done", exec_valid, 0);

    tag = "R8"; host_dir(31); host_act(31, 1, 32'hFFFF); tick(); tick();
    chk("R8 no exec", exec_valid, 0);
    chk("R8 no fetch", mrd_valid, 0);

    tag = "R9"; slot_clr[5] = 1; tick(); slot_clr = '0;
    chk("R9 cleared", active[5], 0);
    slot_clr[30] = 1; host_dir(30); slot_clr = '0;
    chk("R9 set wins", active[30], 1);
    exec_ready = 1; tick(); exec_ready = 0;

    tag = "R10";
    for (int i = 0; i < 33; i++) host_dir(i % 31);
    chk("R10 exec_ovf", exec_ovf, 1);
    tag = "R11";
    exec_ready = 1;
    begin
      int n = 0;
      for (int i = 0; i < 40; i++) begin if (exec_valid) n++; tick(); end
      chk("R11 exec depth", n, 32);
    end
    exec_ready = 0;

    tag = "R10";
    for (int i = 0; i < 34; i++) host_act(i % 31, 1, 32'(i));
    tick();
    chk("R10 fetch_ovf", fetch_ovf, 1);
    mrd_ready = 1; exec_ready = 1;
    for (int i = 0; i < 20; i++) begin
      mrd_done = 1; tick(); mrd_done = 0; tick();
    end
    tag = "R11"; tick();
    finish_up();
  end
endmodule